// File: doc/BRIEF.md
# In-Order Issue Hazard Scoreboard

This block decides, cycle by cycle, whether the single decoded instruction waiting at the issue stage of an in-order, single-issue pipeline may leave. The instruction is described by its unit class (integer, floating-point add, multiply or divide), its destination and two source register indices with enable flags, and three kind flags: load, store and branch. The block holds `in_ready` low while any data, structural or floating-point writeback hazard remains. When `in_valid` and `in_ready` are both high, it pulses `issue`, and on that clock edge it records the new result's timing in its own state.

The state holds three things. Each register has a countdown of cycles until its pending result can be consumed. Each functional unit has a countdown of cycles until it accepts new work. A shift map reserves the future cycles in which floating-point register writes will land. Every countdown falls by one per cycle and stops at zero. The unit latencies, unit counts and pipelining choices are parameters. With zero divide units, divides run on the multiply units.

Top module: `sb_issue_ctrl`

## Requirements
- R1: A source register whose enable is high stalls issue while its pending count is nonzero. A source whose enable is low (an immediate or absent operand) never stalls.
- R2: An instruction with its destination enable high stalls while that destination's pending count is nonzero (write-after-write).
- R3: For a store (`in_store`=1), the second source is its data operand. It stalls only while its pending count exceeds one.
- R4: Latencies are as follows. Integer ALU and branch operations take 1. Loads and stores take 2. Add, multiply and divide take their parameters. On issue, the destination's pending count is loaded with latency minus one. So a dependent ALU operation right after an ALU operation issues at once, and one right after a load stalls exactly one cycle.
- R5: When every unit of the selected class has a nonzero busy count, issue stalls. A non-pipelined unit is loaded with latency minus one on issue. With the default single non-pipelined divide unit of latency 8, a second divide right after the first stalls 7 cycles.
- R6: A unit class configured as pipelined is never marked busy. Back-to-back multiplies both issue without a stall.
- R7: With zero divide units, a divide uses the multiply units with their pipelining setting and keeps the divide latency.
- R8: A write to a floating-point register (index 32 to 63, MSB of the 6-bit index set) completes latency cycles after issue, or latency minus one for a load. It stalls if another floating-point write already lands in that cycle. The check repeats each cycle until the slot is free.
- R9: A branch (`in_branch`=1) whose first source equals the destination of an ALU operation issued in the previous cycle stalls one cycle. It also stalls one cycle when that source equals the destination of a load issued two cycles earlier (now in MEM).
- R10: Register 0 never becomes pending. Writing it creates no hazard.
- R11: `issue` equals `in_valid` AND `in_ready`. No state changes in a cycle where `in_valid` is low.
- R12: Reset clears every pending count, busy count, writeback reservation and branch tracking entry, so an idle block reports `in_ready` high.
- R13: Every count falls by exactly one per cycle unless it is reloaded, and it holds at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded instruction present |
| in_cls | input | 2 | Unit class: 0 integer, 1 FP add, 2 FP multiply, 3 FP divide |
| in_rd | input | 6 | Destination register index |
| in_rs1 | input | 6 | First source register index |
| in_rs2 | input | 6 | Second source register index |
| in_rd_en | input | 1 | Instruction writes `in_rd` |
| in_rs1_en | input | 1 | First source is a register operand |
| in_rs2_en | input | 1 | Second source is a register operand |
| in_load | input | 1 | Instruction is a load (integer class) |
| in_store | input | 1 | Instruction is a store (integer class) |
| in_branch | input | 1 | Instruction is a branch (integer class) |
| in_ready | output | 1 | No hazard; instruction may issue this cycle |
| issue | output | 1 | Issue pulse, state updated on this edge |

## Verification
The assertions assume that the kind flags are used only with the integer class, and that at most one of load, store and branch is set. They also assume a held instruction keeps its fields stable while it waits. The temporal checks compare each issued instruction against the one issued just before it. The stimulus table and the directed sequences keep to this: each flag appears only on integer-class vectors, and a stalled divide is held unchanged until it issues. Parameters are kept at latencies of at least one, so every write lands in a reservable slot.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int REG_CNT = 64;
    localparam int REG_IW  = 6;

    typedef enum logic [1:0] {
        CLS_INT = 2'd0,
        CLS_ADD = 2'd1,
        CLS_MUL = 2'd2,
        CLS_DIV = 2'd3
    } ucls_e;
endpackage

// File: rtl/sb_reg_table.sv
module sb_reg_table #(
    parameter int NREG = 64,
    parameter int IW   = 6,
    parameter int CW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rs1,
    input  logic [IW-1:0] rs2,
    input  logic [IW-1:0] rd,
    input  logic          rs1_chk,
    input  logic          rs2_chk,
    input  logic          rd_chk,
    input  logic          rs2_late,
    input  logic          set_en,
    input  logic [IW-1:0] set_rd,
    input  logic [CW-1:0] set_val,
    output logic          hazard
);
    typedef struct packed {
        logic [NREG-1:0][CW-1:0] pend;
    } tbl_t;

    tbl_t st_d, st_q;
    logic [CW-1:0] p1, p2, pd;
    logic raw1, raw2, waw;

    always_comb begin
        st_d = st_q;
        for (int r = 0; r < NREG; r++) begin
            if (st_q.pend[r] != '0)
                st_d.pend[r] = st_q.pend[r] - CW'(1);
            if (set_en && set_rd == IW'(r) && r != 0)
                st_d.pend[r] = set_val;
        end
    end

    always_comb begin
        p1   = st_q.pend[rs1];
        p2   = st_q.pend[rs2];
        pd   = st_q.pend[rd];
        raw1 = rs1_chk && (p1 != '0);
        raw2 = rs2_chk && (rs2_late ? (p2 > CW'(1)) : (p2 != '0));
        waw  = rd_chk && (pd != '0);
        hazard = raw1 || raw2 || waw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_r0_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend[0] == '0);

    for (genvar g = 0; g < NREG; g++) begin : g_dec
        p_pend_dec_r13: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(st_q.pend[g]) != '0 && !$past(set_en && set_rd == IW'(g)))
            |-> st_q.pend[g] == $past(st_q.pend[g]) - CW'(1));
    end
endmodule

// File: rtl/sb_unit_pool.sv
module sb_unit_pool #(
    parameter int UNITS = 1,
    parameter int CW    = 4,
    parameter bit PIPED = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [CW-1:0] hold,
    output logic          avail
);
    typedef struct packed {
        logic [UNITS-1:0][CW-1:0] busy;
    } pool_t;

    pool_t st_d, st_q;
    logic [UNITS-1:0] free;
    logic found;

    always_comb begin
        for (int u = 0; u < UNITS; u++)
            free[u] = (st_q.busy[u] == '0);
    end

    assign avail = |free;

    always_comb begin
        st_d  = st_q;
        found = 1'b0;
        for (int u = 0; u < UNITS; u++) begin
            if (st_q.busy[u] != '0)
                st_d.busy[u] = st_q.busy[u] - CW'(1);
            if (take && !found && free[u]) begin
                found = 1'b1;
                if (!PIPED)
                    st_d.busy[u] = hold;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_take_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> avail);

    if (!PIPED && UNITS == 1) begin : g_single
        p_hold_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (take && hold != '0) |=> !avail);
    end
endmodule

// File: rtl/sb_wb_slots.sv
module sb_wb_slots #(
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] idx,
    input  logic          book,
    output logic          clash
);
    localparam int SLOTS = 1 << LW;

    typedef struct packed {
        logic [SLOTS-1:0] map;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d.map = st_q.map >> 1;
        if (book && idx != '0)
            st_d.map[idx - LW'(1)] = 1'b1;
    end

    assign clash = st_q.map[idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_book_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        book |-> !clash);
endmodule

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl
    import sb_pkg::*;
#(
    parameter int INT_UNITS = 2,
    parameter int ADD_UNITS = 1,
    parameter int MUL_UNITS = 1,
    parameter int DIV_UNITS = 1,
    parameter int ADD_LAT   = 2,
    parameter int MUL_LAT   = 4,
    parameter int DIV_LAT   = 8,
    parameter bit ADD_PIPE  = 1'b1,
    parameter bit MUL_PIPE  = 1'b1,
    parameter bit DIV_PIPE  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_cls,
    input  logic [REG_IW-1:0] in_rd,
    input  logic [REG_IW-1:0] in_rs1,
    input  logic [REG_IW-1:0] in_rs2,
    input  logic              in_rd_en,
    input  logic              in_rs1_en,
    input  logic              in_rs2_en,
    input  logic              in_load,
    input  logic              in_store,
    input  logic              in_branch,
    output logic              in_ready,
    output logic              issue
);
    localparam int MAX_AM  = (ADD_LAT > MUL_LAT) ? ADD_LAT : MUL_LAT;
    localparam int MAX_AMD = (MAX_AM > DIV_LAT) ? MAX_AM : DIV_LAT;
    localparam int MAX_LAT = (MAX_AMD > 2) ? MAX_AMD : 2;
    localparam int LW      = $clog2(MAX_LAT + 1);

    typedef struct packed {
        logic              alu_v;
        logic [REG_IW-1:0] alu_rd;
        logic              ld1_v;
        logic [REG_IW-1:0] ld1_rd;
        logic              ld2_v;
        logic [REG_IW-1:0] ld2_rd;
    } trk_t;

    trk_t trk_d, trk_q;
    ucls_e cls, eff;
    logic [LW-1:0] lat, wb_idx, hold;
    logic mem_op, alu_op, writes, fp_wr, br_hz, unit_ok;
    logic reg_hz, wb_clash;
    logic [3:0] avail;

    always_comb begin
        cls    = ucls_e'(in_cls);
        mem_op = in_load || in_store;
        unique case (cls)
            CLS_INT: lat = mem_op ? LW'(2) : LW'(1);
            CLS_ADD: lat = LW'(ADD_LAT);
            CLS_MUL: lat = LW'(MUL_LAT);
            default: lat = LW'(DIV_LAT);
        endcase
        eff     = (cls == CLS_DIV && DIV_UNITS == 0) ? CLS_MUL : cls;
        unit_ok = avail[eff];
        writes  = in_rd_en && (in_rd != '0);
        fp_wr   = in_rd_en && in_rd[REG_IW-1];
        wb_idx  = lat - (in_load ? LW'(1) : LW'(0));
        hold    = lat - LW'(1);
        alu_op  = (cls == CLS_INT) && !mem_op && !in_branch;
        br_hz   = in_branch && in_rs1_en &&
                  ((trk_q.alu_v && trk_q.alu_rd == in_rs1) ||
                   (trk_q.ld2_v && trk_q.ld2_rd == in_rs1));
        in_ready = !reg_hz && unit_ok && !(fp_wr && wb_clash) && !br_hz;
        issue    = in_valid && in_ready;

        trk_d.alu_v  = issue && alu_op && writes;
        trk_d.alu_rd = in_rd;
        trk_d.ld1_v  = issue && in_load && writes;
        trk_d.ld1_rd = in_rd;
        trk_d.ld2_v  = trk_q.ld1_v;
        trk_d.ld2_rd = trk_q.ld1_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    sb_reg_table #(.NREG(REG_CNT), .IW(REG_IW), .CW(LW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rs1      (in_rs1),
        .rs2      (in_rs2),
        .rd       (in_rd),
        .rs1_chk  (in_rs1_en),
        .rs2_chk  (in_rs2_en),
        .rd_chk   (in_rd_en),
        .rs2_late (in_store),
        .set_en   (issue && writes),
        .set_rd   (in_rd),
        .set_val  (hold),
        .hazard   (reg_hz)
    );

    sb_wb_slots #(.LW(LW)) u_slots (
        .clk   (clk),
        .rst_n (rst_n),
        .idx   (wb_idx),
        .book  (issue && fp_wr),
        .clash (wb_clash)
    );

    sb_unit_pool #(.UNITS(INT_UNITS), .CW(LW), .PIPED(1'b0)) u_int (
        .clk (clk), .rst_n (rst_n), .take (issue && eff == CLS_INT),
        .hold (hold), .avail (avail[0])
    );

    sb_unit_pool #(.UNITS(ADD_UNITS), .CW(LW), .PIPED(ADD_PIPE)) u_add (
        .clk (clk), .rst_n (rst_n), .take (issue && eff == CLS_ADD),
        .hold (hold), .avail (avail[1])
    );

    sb_unit_pool #(.UNITS(MUL_UNITS), .CW(LW), .PIPED(MUL_PIPE)) u_mul (
        .clk (clk), .rst_n (rst_n), .take (issue && eff == CLS_MUL),
        .hold (hold), .avail (avail[2])
    );

    if (DIV_UNITS > 0) begin : g_div
        sb_unit_pool #(.UNITS(DIV_UNITS), .CW(LW), .PIPED(DIV_PIPE)) u_div (
            .clk (clk), .rst_n (rst_n), .take (issue && eff == CLS_DIV),
            .hold (hold), .avail (avail[3])
        );
    end else begin : g_nodiv
        assign avail[3] = 1'b0;
    end

    p_waw_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && writes && lat > LW'(1))
        |=> !(issue && in_rd_en && in_rd == $past(in_rd)));

    p_load_use_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && in_load && writes)
        |=> !(issue && in_rs1_en && in_rs1 == $past(in_rd)));

    p_wb_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && fp_wr)
        |=> !(issue && fp_wr && wb_idx == $past(wb_idx) - LW'(1)));

    p_branch_alu_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && alu_op && writes)
        |=> !(issue && in_branch && in_rs1_en && in_rs1 == $past(in_rd)));

    if (DIV_UNITS == 1 && !DIV_PIPE && DIV_LAT > 1) begin : g_divchk
        p_div_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (issue && cls == CLS_DIV) |=> !(issue && cls == CLS_DIV));
    end
endmodule

// File: tb/sb_issue_ctrl_tb.sv
module sb_issue_ctrl_tb;
    typedef struct packed {
        logic       v;
        logic [1:0] cls;
        logic [5:0] rd;
        logic [5:0] rs1;
        logic [5:0] rs2;
        logic       rde;
        logic       r1e;
        logic       r2e;
        logic       ld;
        logic       st;
        logic       br;
        logic       rdy;
    } vec_t;

    localparam int NV = 27;
    // fields: v cls rd rs1 rs2 rde r1e r2e ld st br expected_ready
    localparam vec_t TBL [NV] = '{
        '{1'b0,2'd0,6'd13,6'd2,6'd0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1},
        '{1'b1,2'd0,6'd14,6'd13,6'd0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1},
        '{1'b1,2'd0,6'd1,6'd2,6'd3,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1},
        '{1'b1,2'd0,6'd0,6'd1,6'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0},
        '{1'b1,2'd0,6'd0,6'd1,6'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1},
        '{1'b1,2'd0,6'd5,6'd2,6'd0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1},
        '{1'b1,2'd0,6'd6,6'd5,6'd0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0},
        '{1'b1,2'd0,6'd6,6'd5,6'd0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1},
        '{1'b1,2'd0,6'd7,6'd2,6'd0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1},
        '{1'b1,2'd0,6'd0,6'd7,6'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0},
        '{1'b1,2'd0,6'd0,6'd7,6'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0},
        '{1'b1,2'd0,6'd0,6'd7,6'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1},
        '{1'b1,2'd0,6'd8,6'd2,6'd0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1},
        '{1'b1,2'd0,6'd0,6'd9,6'd8,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1},
        '{1'b1,2'd0,6'd10,6'd2,6'd0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1},
        '{1'b1,2'd0,6'd11,6'd2,6'd10,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0},
        '{1'b1,2'd1,6'd33,6'd34,6'd35,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1},
        '{1'b1,2'd0,6'd12,6'd1,6'd33,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1},
        '{1'b1,2'd2,6'd40,6'd34,6'd35,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1},
        '{1'b1,2'd1,6'd40,6'd34,6'd35,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0},
        '{1'b1,2'd1,6'd41,6'd34,6'd35,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0},
        '{1'b1,2'd1,6'd41,6'd34,6'd35,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1},
        '{1'b1,2'd0,6'd0,6'd2,6'd0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1},
        '{1'b1,2'd0,6'd15,6'd0,6'd0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1},
        '{1'b1,2'd2,6'd44,6'd34,6'd35,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1},
        '{1'b1,2'd2,6'd45,6'd34,6'd35,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1},
        '{1'b1,2'd3,6'd42,6'd34,6'd35,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1}
    };
    localparam string TAG [NV] = '{
        "R11", "R11", "R4", "R9", "R9", "R4", "R4", "R13", "R4", "R1",
        "R9", "R9", "R4", "R3", "R5", "R1", "R8", "R1", "R6", "R2",
        "R8", "R8", "R10", "R10", "R6", "R6", "R5"
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid, in_rd_en, in_rs1_en, in_rs2_en, in_load, in_store, in_branch;
    logic [1:0] in_cls;
    logic [5:0] in_rd, in_rs1, in_rs2;
    logic in_ready, issue, nd_ready, nd_issue;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sb_issue_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
        .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2), .in_rd_en(in_rd_en),
        .in_rs1_en(in_rs1_en), .in_rs2_en(in_rs2_en), .in_load(in_load),
        .in_store(in_store), .in_branch(in_branch), .in_ready(in_ready),
        .issue(issue)
    );

    sb_issue_ctrl #(.DIV_UNITS(0)) u_nodiv (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
        .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2), .in_rd_en(in_rd_en),
        .in_rs1_en(in_rs1_en), .in_rs2_en(in_rs2_en), .in_load(in_load),
        .in_store(in_store), .in_branch(in_branch), .in_ready(nd_ready),
        .issue(nd_issue)
    );

    task automatic drive(input vec_t x);
        in_valid  = x.v;   in_cls    = x.cls;
        in_rd     = x.rd;  in_rs1    = x.rs1;  in_rs2 = x.rs2;
        in_rd_en  = x.rde; in_rs1_en = x.r1e;  in_rs2_en = x.r2e;
        in_load   = x.ld;  in_store  = x.st;   in_branch = x.br;
    endtask

    task automatic check(input int got, input int exp, input string req, input string what);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    initial begin
        int stalls;
        vec_t w;
        drive(TBL[0]);
        repeat (2) @(negedge clk);
        #1;
        check(int'(issue), 0, "R12", "issue during reset");
        check(int'(in_ready), 1, "R12", "ready during reset");
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(TBL[i]);
            #1;
            check(int'(in_ready), int'(TBL[i].rdy), TAG[i], $sformatf("row %0d ready", i));
            check(int'(issue), int'(TBL[i].v & TBL[i].rdy), "R11", $sformatf("row %0d issue", i));
        end

        // second divide right after the first: non-pipelined unit, latency 8
        w = '{1'b1,2'd3,6'd43,6'd34,6'd35,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0};
        @(negedge clk);
        drive(w);
        #1;
        check(int'(nd_ready), 1, "R7", "divide on pipelined multiply pool");
        stalls = 0;
        while (!in_ready && stalls < 20) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        check(stalls, 7, "R5", "divide busy stall cycles");
        check(int'(in_ready), 1, "R5", "divide issues after busy");

        // pending multiply result and busy divider, then reset
        @(negedge clk);
        drive('{1'b1,2'd2,6'd50,6'd34,6'd35,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0});
        #1;
        check(int'(in_ready), 1, "R6", "multiply issues");
        @(negedge clk);
        drive('{1'b0,2'd3,6'd46,6'd34,6'd35,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0});
        #1;
        check(int'(in_ready), 0, "R5", "divider still busy");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(int'(in_ready), 1, "R12", "divider free after reset");
        drive('{1'b0,2'd0,6'd16,6'd50,6'd0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0});
        #1;
        check(int'(in_ready), 1, "R12", "pending count cleared by reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule